// File: doc/BRIEF.md
# Per-Channel Signalling Debounce Store

This block keeps the four signalling bits of every voice channel that arrive in the signalling timeslot of a received 30-channel PCM link. A decoder upstream presents each channel's nibble as a write (channel index plus four bits). The store accepts a new value only after it has stayed the same for several 2 ms periods. A single corrupted bit therefore never reaches the call-control logic.

A read port, addressed by channel, returns the debounced nibble and a valid flag for a downstream serializer. The store only trusts its contents while the receiver is synchronized. When synchronization drops with debouncing on, the old values stay readable for a bounded hold of three tick periods (6 ms). After that the port reads all ones and the flag is low. With debouncing off, writes land at once and the flag simply mirrors the sync input.

Top module: `sigdb_store`

## Requirements
- R1: After reset every stored nibble is 4'b1111, and rdValid is low until syncOk goes high.
- R2: With dbEn high, each channel keeps a pending nibble and an age count. Every tick2ms pulse raises the age of every channel by one, up to a ceiling of 3. A write equal to the pending nibble, made while that channel's age is 3, copies the pending nibble into the stored nibble. The stored nibble is readable from the next cycle.
- R3: With dbEn high, a write that differs from the pending nibble replaces the pending nibble and sets that channel's age to 0. The stored nibble does not change.
- R4: With dbEn low, an accepted write puts the nibble straight into the stored and pending values. It is readable from the next cycle.
- R5: A write has no effect while syncOk is low, or when wrCh is 30 or above.
- R6: rdValid is high in every cycle in which syncOk is high.
- R7: With dbEn high, rdValid stays high after syncOk falls, until the third tick2ms pulse after the fall. From then on rdValid is low until syncOk returns.
- R8: When syncOk and dbEn are both low, rdValid is low in that same cycle.
- R9: rdNib is 4'b1111 whenever rdValid is low or rdCh is 30 or above. Otherwise it is the stored nibble of channel rdCh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for one channel nibble |
| wrCh | input | 5 | Channel index of the write (0 to 29) |
| wrNib | input | 4 | Received signalling nibble |
| syncOk | input | 1 | Receiver frame synchronization flag |
| dbEn | input | 1 | Debounce enable |
| tick2ms | input | 1 | One-cycle pulse every 2 ms |
| rdCh | input | 5 | Channel index of the read |
| rdNib | output | 4 | Debounced nibble, or all ones when not valid |
| rdValid | output | 1 | Stored signalling may be used |

## Verification
A pending nibble or age count that has gone wrong stays hidden until the next write to that channel. It then shows as a commit that comes one write too early or too late, or as a glitch that gets through. The bench therefore reads each channel right after every write in a debounce sequence. A stuck hold counter shows at the exact tick where rdValid should fall, so the valid flag is checked both one tick before and on the expiring tick. Writes made while unsynchronized are exposed by the write that follows resynchronization: if they were wrongly accepted, that write commits a value it should not.

// File: rtl/sigdb_pkg.sv
package sigdb_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic load;    // accepted write this cycle
    logic bypass;  // debounce disabled
    logic age;     // advance age counters
    logic show;    // stored data may be shown
  } sigdb_strobe_t;
endpackage

// File: rtl/sigdb_ctrl.sv
module sigdb_ctrl
  import sigdb_pkg::*;
#(
  parameter int NUM_CH     = 30,
  parameter int HOLD_TICKS = 3,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int HOLD_W    = $clog2(HOLD_TICKS + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            wrEn,
  input  logic [CH_W-1:0] wrCh,
  input  logic            syncOk,
  input  logic            dbEn,
  input  logic            tick2ms,
  output sigdb_strobe_t   strobe
);
  logic [HOLD_W-1:0] holdCnt;
  logic holdExpired;

  // count ticks since sync was lost; starts expired after reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdCnt <= HOLD_W'(HOLD_TICKS);
    end else if (syncOk) begin
      holdCnt <= '0;
    end else if (tick2ms && !holdExpired) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  assign holdExpired = (holdCnt == HOLD_W'(HOLD_TICKS));

  always_comb begin
    strobe.load   = wrEn && syncOk && (32'(wrCh) < NUM_CH);
    strobe.bypass = !dbEn;
    strobe.age    = tick2ms;
    strobe.show   = syncOk || (dbEn && !holdExpired);
  end
endmodule

// File: rtl/sigdb_datapath.sv
module sigdb_datapath
  import sigdb_pkg::*;
#(
  parameter int NUM_CH  = 30,
  parameter int NIB_W   = 4,
  parameter int AGE_MAX = 3,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int AGE_W  = $clog2(AGE_MAX + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  sigdb_strobe_t    strobe,
  input  logic [CH_W-1:0]  wrCh,
  input  logic [NIB_W-1:0] wrNib,
  input  logic [CH_W-1:0]  rdCh,
  output logic [NIB_W-1:0] rdNib
);
  logic [NIB_W-1:0] storedNib [NUM_CH];

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [NIB_W-1:0] pendNib;
    logic [AGE_W-1:0] age;
    logic sel, aged;

    assign sel  = strobe.load && (wrCh == CH_W'(ch));
    assign aged = (age == AGE_W'(AGE_MAX));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        storedNib[ch] <= '1;
        pendNib       <= '1;
        age           <= '0;
      end else if (sel && strobe.bypass) begin
        storedNib[ch] <= wrNib;
        pendNib       <= wrNib;
        age           <= '0;
      end else if (sel && (wrNib != pendNib)) begin
        pendNib <= wrNib;
        age     <= '0;
      end else begin
        if (sel && aged) storedNib[ch] <= pendNib;
        if (strobe.age && !aged) age <= age + 1'b1;
      end
    end
  end

  always_comb begin
    rdNib = '1;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (strobe.show && (rdCh == CH_W'(ch))) rdNib = storedNib[ch];
    end
  end
endmodule

// File: rtl/sigdb_store.sv
module sigdb_store
  import sigdb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [4:0] wrCh,
  input  logic [3:0] wrNib,
  input  logic       syncOk,
  input  logic       dbEn,
  input  logic       tick2ms,
  input  logic [4:0] rdCh,
  output logic [3:0] rdNib,
  output logic       rdValid
);
  localparam int NUM_CH = 30;
  sigdb_strobe_t strobe;

  sigdb_ctrl #(.NUM_CH(NUM_CH), .HOLD_TICKS(3)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCh(wrCh), .syncOk(syncOk),
    .dbEn(dbEn), .tick2ms(tick2ms), .strobe(strobe)
  );

  sigdb_datapath #(.NUM_CH(NUM_CH), .NIB_W(4), .AGE_MAX(3)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrCh(wrCh), .wrNib(wrNib),
    .rdCh(rdCh), .rdNib(rdNib)
  );

  assign rdValid = strobe.show;
endmodule

// File: rtl/sigdb_store_chk.sv
module sigdb_store_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [4:0] wrCh,
  input logic       syncOk,
  input logic       dbEn,
  input logic [4:0] rdCh,
  input logic [3:0] rdNib,
  input logic       rdValid
);
  // R6
  sync_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    syncOk |-> rdValid);

  // R8
  nosync_bypass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!syncOk && !dbEn) |-> !rdValid);

  // R9
  blank_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdValid || rdCh >= 5'd30) |-> (rdNib == 4'hF));

  // R7
  hold_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dbEn && $fell(syncOk)) |-> rdValid);

  // R5
  no_write_no_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(rdValid) && $stable(rdCh) && $past(rstN) &&
     !$past(wrEn && syncOk && wrCh == rdCh)) |-> $stable(rdNib));
endmodule

bind sigdb_store sigdb_store_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCh(wrCh), .syncOk(syncOk),
  .dbEn(dbEn), .rdCh(rdCh), .rdNib(rdNib), .rdValid(rdValid)
);

// File: tb/sigdb_store_tb.sv
module sigdb_store_tb;
  logic clk = 0;
  logic rstN = 0;
  logic wrEn = 0;
  logic [4:0] wrCh = 0;
  logic [3:0] wrNib = 0;
  logic syncOk = 0;
  logic dbEn = 1;
  logic tick2ms = 0;
  logic [4:0] rdCh = 0;
  logic [3:0] rdNib;
  logic rdValid;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  sigdb_store u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCh(wrCh), .wrNib(wrNib),
    .syncOk(syncOk), .dbEn(dbEn), .tick2ms(tick2ms), .rdCh(rdCh),
    .rdNib(rdNib), .rdValid(rdValid)
  );

  // {ticks before write, channel, nibble written, expected read after}
  localparam logic [14:0] VEC [0:10] = '{
    {2'd0, 5'd5,  4'h3, 4'hF},  // R3 new pending
    {2'd1, 5'd5,  4'h3, 4'hF},  // R2 age 1
    {2'd1, 5'd5,  4'h3, 4'hF},  // R2 age 2
    {2'd1, 5'd5,  4'h3, 4'h3},  // R2 age 3 commit
    {2'd0, 5'd5,  4'h7, 4'h3},  // R3 glitch starts
    {2'd2, 5'd5,  4'h3, 4'h3},  // R3 glitch dropped
    {2'd3, 5'd5,  4'h3, 4'h3},  // R2 same value
    {2'd3, 5'd6,  4'hA, 4'hF},  // R3 aged but differs
    {2'd3, 5'd6,  4'hA, 4'hA},  // R2 commit
    {2'd0, 5'd29, 4'h0, 4'hF},  // R3 top channel
    {2'd3, 5'd29, 4'h0, 4'h0}   // R2 top channel commit
  };

  task automatic check(input string tag, input logic [3:0] expNib, input logic expValid);
    #1;
    checks++;
    if (rdNib !== expNib || rdValid !== expValid) begin
      errors++;
      $display("FAIL %s: rdNib=%h rdValid=%b expected rdNib=%h rdValid=%b",
               tag, rdNib, rdValid, expNib, expValid);
    end
  endtask

  task automatic tick();
    @(negedge clk) tick2ms = 1;
    @(negedge clk) tick2ms = 0;
  endtask

  task automatic write(input logic [4:0] ch, input logic [3:0] nib);
    @(negedge clk) begin wrEn = 1; wrCh = ch; wrNib = nib; end
    @(negedge clk) wrEn = 0;
  endtask

  initial begin
    #400000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    rdCh = 0;
    check("R1 reset invalid", 4'hF, 1'b0);
    syncOk = 1;
    check("R1 reset nibble / R6", 4'hF, 1'b1);

    foreach (VEC[i]) begin
      for (int t = 0; t < int'(VEC[i][14:13]); t++) tick();
      write(VEC[i][12:8], VEC[i][7:4]);
      rdCh = VEC[i][12:8];
      check($sformatf("R2/R3 vector %0d", i), VEC[i][3:0], 1'b1);
    end

    // R5 out-of-range channel
    write(5'd30, 4'h0);
    rdCh = 5'd30;
    check("R5/R9 channel 30", 4'hF, 1'b1);
    rdCh = 5'd5;
    check("R5 ch5 untouched", 4'h3, 1'b1);

    // R4 bypass
    dbEn = 0;
    write(5'd7, 4'h5);
    rdCh = 5'd7;
    check("R4 bypass write", 4'h5, 1'b1);
    @(negedge clk) syncOk = 0;
    check("R8 bypass valid follows sync", 4'hF, 1'b0);
    dbEn = 1;
    check("R7 hold active on re-enable", 4'h5, 1'b1);

    // R5 writes ignored while unsynchronized; R7 hold expiry
    rdCh = 5'd5;
    write(5'd5, 4'h9);
    tick();
    tick();
    check("R7 valid after 2 ticks", 4'h3, 1'b1);
    tick();
    check("R7 expired after 3 ticks", 4'hF, 1'b0);
    @(negedge clk) syncOk = 1;
    check("R6 resync restores", 4'h3, 1'b1);
    write(5'd5, 4'h9);
    check("R5 write during loss ignored", 4'h3, 1'b1);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule